// File: doc/BRIEF.md
# Two-Wire Programming Table-Write Engine

This block is the target side of a two-wire in-circuit programming port. A host drives a serial clock and a data line. The block frames the bits into transactions of a 4-bit command and a 16-bit payload. It decodes each transaction. The core-instruction command executes a small set of instructions. These instructions load a working byte, copy it into a 22-bit table pointer, and set or clear three mode flags: program select, configuration select and write enable.

The two table-write commands fill a byte-wide write buffer or arm a single configuration byte. Either one can then start a timed programming cycle. After the start, the host sends the next command and keeps the serial clock high on its fourth bit for a hold time. The block counts that hold time in system clock cycles. When the hold time has elapsed, the block writes the armed bytes out one per cycle on a simple memory write port. If the host ends the high phase too early, the block discards the armed data and raises an error flag.

Top module: `icsp_tw_engine`

## Requirements
- R1: A transaction is 20 serial bits, shifted in least significant bit first and sampled on the falling serial clock edge. Bits 0 to 3 form the command and bits 4 to 19 form the payload. The transaction executes after its 20th falling edge.
- R2: For command 0000 (core instruction), payload 0x0Ekk loads kk into the working byte. Payloads 0x6EF8, 0x6EF7 and 0x6EF6 copy the working byte into table pointer bits [21:16] (low 6 bits of the byte), [15:8] and [7:0].
- R3: For command 0000, a payload of the form 100c bbb0 1010 0110 (low byte 0xA6) sets the flag numbered bbb when c=0 and clears it when c=1. Bit 7 is program select, bit 6 is configuration select and bit 2 is write enable. For example, 0x8EA6 sets program select, 0x8CA6 sets configuration select, 0x9CA6 clears configuration select and 0x84A6 sets write enable.
- R4: In buffered mode (configuration select clear), command 1101 stores the payload low byte at buffer index (pointer mod 8) and the high byte at the next index. It then advances the table pointer by 2.
- R5: In buffered mode, command 1111 stores its two bytes in the same way and starts programming without advancing the pointer. At completion, each stored byte is written once, in ascending index order, at the address formed by the start pointer with its low 3 bits replaced by the index.
- R6: In configuration mode, command 1111 arms one byte at the current pointer. The byte is the payload low byte if the pointer is even and the high byte if it is odd. The pointer never advances in this mode, and command 1101 is ignored.
- R7: Table writes are ignored when write enable is clear, or when both program select and configuration select are clear.
- R8: After a programming start, the block counts system clock cycles while the serial clock is high during the fourth command bit of the next transaction. After P9_CYC such cycles it writes the armed bytes, one per cycle, while the serial clock is still high. busy_o is high from the start until the last byte is written.
- R9: If the serial clock falls during that fourth bit before P9_CYC cycles have elapsed, err_o goes high, nothing is written, the armed data is discarded and busy_o drops. err_o clears at the next programming start.
- R10: After reset, mem_we_o, busy_o and err_o are low, all three flags are clear and the table pointer is zero.
- R11: Each mem_we_o pulse lasts one system clock cycle per byte, and mem_we_o is high only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial programming clock from the host |
| sdata_i | input | 1 | Serial programming data from the host |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_addr_o | output | 22 | Memory byte address |
| mem_data_o | output | 8 | Memory write data |
| busy_o | output | 1 | Programming cycle in progress |
| err_o | output | 1 | Hold phase ended before P9_CYC cycles had elapsed |

## Verification
Full buffered loads are swept over several block bases: the start of the boot block, its last block, a mid block and the ID block. Each run uses a different arithmetic byte pattern, so a lane swap, a missed pointer increment or a wrong block base each shows up as a wrong address or data byte. A short load starting mid-block separates writing only the stored indices from writing the whole buffer. Configuration writes sweep even and odd addresses, repeat a write without reloading the pointer, and send an interleaved 1101. These cases tell lane steering apart from auto-increment. Table writes with write enable clear or with both select flags clear, and a hold that ends early, must all produce no write at all, and the early hold must also raise the error flag.

// File: rtl/icsp_pkg.sv
package icsp_pkg;
  localparam int CMD_W = 4;
  localparam int PAY_W = 16;

  localparam logic [CMD_W-1:0] CMD_CORE    = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_TW_INC2 = 4'b1101;
  localparam logic [CMD_W-1:0] CMD_TW_PROG = 4'b1111;

  localparam logic [7:0] OP_MOVLW = 8'h0E;
  localparam logic [7:0] OP_MOVWF = 8'h6E;
  localparam logic [7:0] REG_CTRL = 8'hA6;
  localparam logic [7:0] REG_PTRU = 8'hF8;
  localparam logic [7:0] REG_PTRH = 8'hF7;
  localparam logic [7:0] REG_PTRL = 8'hF6;

  localparam logic [2:0] BIT_PSEL = 3'd7;
  localparam logic [2:0] BIT_CSEL = 3'd6;
  localparam logic [2:0] BIT_WREN = 3'd2;

  typedef enum logic [1:0] {
    PG_IDLE,
    PG_ARMED,
    PG_DRAIN
  } pg_state_e;
endpackage

// File: rtl/icsp_rx.sv
module icsp_rx
  import icsp_pkg::*;
#(
  parameter int CW = CMD_W,
  parameter int PW = PAY_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sclk_i,
  input  logic                          sdata_i,
  output logic                          frame_vld_o,
  output logic [CW-1:0]                 cmd_o,
  output logic [PW-1:0]                 pay_o,
  output logic [$clog2(CW+PW)-1:0]      bit_idx_o,
  output logic                          sclk_hi_o,
  output logic                          sclk_fall_o
);
  localparam int FR_W = CW + PW;
  localparam int BC_W = $clog2(FR_W);

  logic [1:0]      sclk_sync, sdat_sync;
  logic            sclk_d;
  logic [FR_W-1:0] sr_q;
  logic [BC_W-1:0] bit_cnt_q;
  logic            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sync <= '0;
      sdat_sync <= '0;
      sclk_d    <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[0], sclk_i};
      sdat_sync <= {sdat_sync[0], sdata_i};
      sclk_d    <= sclk_sync[1];
    end
  end

  assign sclk_fall_o = sclk_d & ~sclk_sync[1];
  assign sclk_hi_o   = sclk_sync[1];

  // LSB first: new bit enters at the top, shifts toward bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      bit_cnt_q <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (sclk_fall_o) begin
        sr_q <= {sdat_sync[1], sr_q[FR_W-1:1]};
        if (bit_cnt_q == BC_W'(FR_W-1)) begin
          bit_cnt_q <= '0;
          vld_q     <= 1'b1;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  assign frame_vld_o = vld_q;
  assign cmd_o       = sr_q[CW-1:0];
  assign pay_o       = sr_q[FR_W-1:CW];
  assign bit_idx_o   = bit_cnt_q;

  AST_FRAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o); // R1
endmodule

// File: rtl/icsp_core.sv
module icsp_core
  import icsp_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [PAY_W-1:0]  pay_i,
  input  logic              inc2_i,
  output logic [ADDR_W-1:0] tblptr_o,
  output logic              psel_o,
  output logic              csel_o,
  output logic              wren_o
);
  localparam int UP_W = ADDR_W - 16;

  logic [7:0]        w_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              psel_q, csel_q, wren_q;
  logic              exec;
  logic              bitop;

  assign exec  = frame_vld_i && (cmd_i == CMD_CORE);
  assign bitop = (pay_i[15:13] == 3'b100) && !pay_i[8] && (pay_i[7:0] == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      ptr_q  <= '0;
      psel_q <= 1'b0;
      csel_q <= 1'b0;
      wren_q <= 1'b0;
    end else if (inc2_i) begin
      ptr_q <= ptr_q + ADDR_W'(2);
    end else if (exec) begin
      if (pay_i[15:8] == OP_MOVLW) begin
        w_q <= pay_i[7:0];
      end else if (pay_i[15:8] == OP_MOVWF) begin
        case (pay_i[7:0])
          REG_PTRU: ptr_q[ADDR_W-1:16] <= w_q[UP_W-1:0];
          REG_PTRH: ptr_q[15:8]        <= w_q;
          REG_PTRL: ptr_q[7:0]         <= w_q;
          default: ;
        endcase
      end else if (bitop) begin
        // pay[12]: 0 = set, 1 = clear
        case (pay_i[11:9])
          BIT_PSEL: psel_q <= ~pay_i[12];
          BIT_CSEL: csel_q <= ~pay_i[12];
          BIT_WREN: wren_q <= ~pay_i[12];
          default: ;
        endcase
      end
    end
  end

  assign tblptr_o = ptr_q;
  assign psel_o   = psel_q;
  assign csel_o   = csel_q;
  assign wren_o   = wren_q;

  AST_PTR_STEP2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc2_i |=> (tblptr_o[0] == $past(tblptr_o[0]))); // R4
endmodule

// File: rtl/icsp_prog.sv
module icsp_prog
  import icsp_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BUF_BYTES = 8,
  parameter int P9_CYC    = 4800,
  parameter int BC_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [PAY_W-1:0]  pay_i,
  input  logic [ADDR_W-1:0] tblptr_i,
  input  logic              psel_i,
  input  logic              csel_i,
  input  logic              wren_i,
  input  logic [BC_W-1:0]   bit_idx_i,
  input  logic              sclk_hi_i,
  input  logic              sclk_fall_i,
  output logic              inc2_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int CNT_W = $clog2(P9_CYC + 1);
  localparam logic [BC_W-1:0] HOLD_IDX = BC_W'(CMD_W - 1);

  pg_state_e            state_q;
  logic [7:0]           wbuf_q [BUF_BYTES];
  logic [BUF_BYTES-1:0] bvld_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     ptr_q;
  logic [ADDR_W-1:0]    base_q;
  logic [7:0]           cbyte_q;
  logic                 cfg_q;
  logic                 err_q;

  logic             accept, tw_inc, tw_prog, deposit, in_hold;
  logic [IDX_W-1:0] idx0, idx1;

  assign accept  = frame_vld_i && (state_q == PG_IDLE) && wren_i && (psel_i || csel_i);
  assign tw_inc  = accept && (cmd_i == CMD_TW_INC2) && !csel_i;
  assign tw_prog = accept && (cmd_i == CMD_TW_PROG);
  assign deposit = tw_inc || (tw_prog && !csel_i);
  assign inc2_o  = tw_inc;
  assign idx0    = tblptr_i[IDX_W-1:0];
  assign idx1    = idx0 + 1'b1;
  assign in_hold = (bit_idx_i == HOLD_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PG_IDLE;
      bvld_q  <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      base_q  <= '0;
      cbyte_q <= '0;
      cfg_q   <= 1'b0;
      err_q   <= 1'b0;
      for (int i = 0; i < BUF_BYTES; i++) wbuf_q[i] <= '0;
    end else begin
      case (state_q)
        PG_IDLE: begin
          if (deposit) begin
            wbuf_q[idx0] <= pay_i[7:0];
            wbuf_q[idx1] <= pay_i[15:8];
            bvld_q[idx0] <= 1'b1;
            bvld_q[idx1] <= 1'b1;
          end
          if (tw_prog) begin
            state_q <= PG_ARMED;
            cfg_q   <= csel_i;
            base_q  <= csel_i ? tblptr_i : {tblptr_i[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
            cbyte_q <= tblptr_i[0] ? pay_i[15:8] : pay_i[7:0];
            cnt_q   <= '0;
            err_q   <= 1'b0;
          end
        end
        PG_ARMED: begin
          if (sclk_fall_i && in_hold) begin
            // hold ended early: abort
            err_q   <= 1'b1;
            bvld_q  <= '0;
            state_q <= PG_IDLE;
          end else if (sclk_hi_i && in_hold) begin
            if (cnt_q == CNT_W'(P9_CYC - 1)) begin
              state_q <= PG_DRAIN;
              ptr_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PG_DRAIN: begin
          if (cfg_q || (ptr_q == IDX_W'(BUF_BYTES - 1))) begin
            state_q <= PG_IDLE;
            bvld_q  <= '0;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        default: state_q <= PG_IDLE;
      endcase
    end
  end

  assign mem_we_o   = (state_q == PG_DRAIN) && (cfg_q || bvld_q[ptr_q]);
  assign mem_addr_o = !mem_we_o ? '0 :
                      cfg_q ? base_q : {base_q[ADDR_W-1:IDX_W], ptr_q};
  assign mem_data_o = !mem_we_o ? '0 : (cfg_q ? cbyte_q : wbuf_q[ptr_q]);
  assign busy_o     = (state_q != PG_IDLE);
  assign err_o      = err_q;

  AST_WE_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> sclk_hi_i); // R8
  AST_DRAIN_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o) && !cfg_q) |-> (mem_addr_o > $past(mem_addr_o))); // R5
  AST_CFG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && cfg_q) |=> !mem_we_o); // R6
  AST_ERR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!busy_o && !mem_we_o)); // R9
endmodule

// File: rtl/icsp_tw_engine.sv
module icsp_tw_engine
  import icsp_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BUF_BYTES = 8,
  parameter int P9_CYC    = 4800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam int BC_W = $clog2(CMD_W + PAY_W);

  logic              frame_vld, sclk_hi, sclk_fall, inc2;
  logic [CMD_W-1:0]  cmd;
  logic [PAY_W-1:0]  pay;
  logic [BC_W-1:0]   bit_idx;
  logic [ADDR_W-1:0] tblptr;
  logic              psel, csel, wren;

  icsp_rx #(.CW(CMD_W), .PW(PAY_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .sdata_i     (sdata_i),
    .frame_vld_o (frame_vld),
    .cmd_o       (cmd),
    .pay_o       (pay),
    .bit_idx_o   (bit_idx),
    .sclk_hi_o   (sclk_hi),
    .sclk_fall_o (sclk_fall)
  );

  icsp_core #(.ADDR_W(ADDR_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .cmd_i       (cmd),
    .pay_i       (pay),
    .inc2_i      (inc2),
    .tblptr_o    (tblptr),
    .psel_o      (psel),
    .csel_o      (csel),
    .wren_o      (wren)
  );

  icsp_prog #(
    .ADDR_W    (ADDR_W),
    .BUF_BYTES (BUF_BYTES),
    .P9_CYC    (P9_CYC),
    .BC_W      (BC_W)
  ) u_prog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .cmd_i       (cmd),
    .pay_i       (pay),
    .tblptr_i    (tblptr),
    .psel_i      (psel),
    .csel_i      (csel),
    .wren_i      (wren),
    .bit_idx_i   (bit_idx),
    .sclk_hi_i   (sclk_hi),
    .sclk_fall_i (sclk_fall),
    .inc2_o      (inc2),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
  );

  AST_WE_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R11
endmodule

// File: tb/icsp_tw_engine_test.sv
`timescale 1ns/1ps
module icsp_tw_engine_test;
  localparam int H  = 6;
  localparam int P9 = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdata = 1'b0;
  logic        mem_we;
  logic [21:0] mem_addr;
  logic [7:0]  mem_data;
  logic        busy, err;

  int n_chk = 0;
  int n_fail = 0;
  int nlog = 0;
  logic [21:0] log_addr [128];
  logic [7:0]  log_data [128];

  always #2 clk = ~clk;

  icsp_tw_engine #(.ADDR_W(22), .BUF_BYTES(8), .P9_CYC(P9)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sclk_i     (sclk),
    .sdata_i    (sdata),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_data_o (mem_data),
    .busy_o     (busy),
    .err_o      (err)
  );

  always @(negedge clk) begin
    if (mem_we && nlog < 128) begin
      log_addr[nlog] = mem_addr;
      log_data[nlog] = mem_data;
      nlog = nlog + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdata = b;
    sclk  = 1'b1;
    repeat (H) @(negedge clk);
    sclk  = 1'b0;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] cmd, input logic [15:0] pay);
    for (int i = 0; i < 4; i++) send_bit(cmd[i]);
    for (int i = 0; i < 16; i++) send_bit(pay[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic core(input logic [15:0] pay);
    send(4'b0000, pay);
  endtask

  task automatic set_ptr(input logic [21:0] a);
    core({8'h0E, 2'b00, a[21:16]}); core(16'h6EF8);
    core({8'h0E, a[15:8]});         core(16'h6EF7);
    core({8'h0E, a[7:0]});          core(16'h6EF6);
  endtask

  // NOP whose 4th command bit stays high for hi cycles; busy checked at cycle 5
  task automatic hold(input int hi, input bit exp_busy, input string req);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    @(negedge clk);
    sdata = 1'b0;
    sclk  = 1'b1;
    for (int i = 0; i < hi; i++) begin
      @(negedge clk);
      if (i == 5) chk(busy == exp_busy, req, busy, exp_busy);
    end
    sclk = 1'b0;
    repeat (H - 1) @(negedge clk);
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((k * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    int s;
    logic [21:0] bases [4];
    bases[0] = 22'h000000; bases[1] = 22'h0007F8;
    bases[2] = 22'h000100; bases[3] = 22'h200000;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!mem_we && !busy && !err, "R10 reset outputs", {mem_we, busy, err}, 0);

    // R7: write enable clear -> ignored (flags and pointer zero after reset, R10)
    s = nlog;
    core(16'h8EA6);
    send(4'b1111, 16'h3322);
    hold(80, 1'b0, "R7 busy with write enable clear");
    chk(nlog == s, "R7 no write with write enable clear", nlog - s, 0);

    core(16'h9CA6);
    core(16'h84A6);

    // R4 R5: full buffered loads over block bases, R2 pointer loads
    for (int k = 0; k < 4; k++) begin
      s = nlog;
      set_ptr(bases[k]);
      for (int j = 0; j < 3; j++) send(4'b1101, {pat(k, 2*j+1), pat(k, 2*j)});
      send(4'b1111, {pat(k, 7), pat(k, 6)});
      hold(80, 1'b1, "R8 busy during hold");
      chk(busy == 1'b0, "R8 busy cleared after write", busy, 0);
      chk(nlog - s == 8, "R5 buffered byte count", nlog - s, 8);
      for (int i = 0; i < 8; i++) begin
        chk(log_addr[s+i] == bases[k] + 22'(i), "R2 R4 buffered address", log_addr[s+i], bases[k] + 22'(i));
        chk(log_data[s+i] == pat(k, i), "R4 R5 buffered data lane", log_data[s+i], pat(k, i));
      end
    end

    // R5: partial load from mid block writes only stored indices
    s = nlog;
    set_ptr(22'h000404);
    send(4'b1101, 16'hBBAA);
    send(4'b1111, 16'hDDCC);
    hold(80, 1'b1, "R8 busy partial");
    chk(nlog - s == 4, "R5 partial byte count", nlog - s, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_addr[s+i] == 22'h000404 + 22'(i), "R5 partial address", log_addr[s+i], 22'h000404 + 22'(i));
      chk(log_data[s+i] == 8'hAA + 8'(i * 17), "R5 partial data", log_data[s+i], 8'hAA + 8'(i * 17));
    end

    // R9: early end of hold
    s = nlog;
    set_ptr(22'h000010);
    send(4'b1111, 16'h2211);
    hold(10, 1'b1, "R9 busy before early fall");
    chk(err == 1'b1, "R9 error flag", err, 1);
    chk(busy == 1'b0, "R9 busy dropped", busy, 0);
    chk(nlog == s, "R9 no write on early fall", nlog - s, 0);
    send(4'b1111, 16'h4433);
    chk(err == 1'b0, "R9 error cleared at start", err, 0);
    hold(80, 1'b1, "R8 busy after error");
    chk(nlog - s == 2, "R9 discarded data not written", nlog - s, 2);
    chk(log_data[s] == 8'h33 && log_data[s+1] == 8'h44, "R9 fresh data only",
        {log_data[s], log_data[s+1]}, 16'h3344);

    // R6: configuration mode byte writes, even/odd steering
    core(16'h8CA6);
    for (int a = 0; a < 4; a++) begin
      logic [15:0] p;
      logic [7:0]  e;
      p = 16'h5A00 + 16'(a * 16'h0101) + 16'h0012;
      e = a[0] ? p[15:8] : p[7:0];
      s = nlog;
      set_ptr(22'h300000 + 22'(a));
      send(4'b1111, p);
      hold(80, 1'b1, "R8 busy config");
      chk(nlog - s == 1, "R6 config single write", nlog - s, 1);
      chk(log_addr[s] == 22'h300000 + 22'(a), "R6 config address", log_addr[s], 22'h300000 + 22'(a));
      chk(log_data[s] == e, "R6 config lane", log_data[s], e);
    end
    // R6: no increment, 1101 ignored (pointer still 0x300003, odd)
    s = nlog;
    send(4'b1101, 16'h7766);
    send(4'b1111, 16'h9988);
    hold(80, 1'b1, "R8 busy config repeat");
    chk(nlog - s == 1, "R6 repeat single write", nlog - s, 1);
    chk(log_addr[s] == 22'h300003, "R6 address not incremented", log_addr[s], 22'h300003);
    chk(log_data[s] == 8'h99, "R6 odd high byte", log_data[s], 8'h99);

    // R7: both select flags clear -> ignored; R3 clear operations
    core(16'h9CA6);
    core(16'h9EA6);
    s = nlog;
    set_ptr(22'h000020);
    send(4'b1111, 16'hF00F);
    hold(80, 1'b0, "R7 busy with selects clear");
    chk(nlog == s, "R3 R7 no write with selects clear", nlog - s, 0);

    // R3: set program select again restores buffered writes; R1 framing
    core(16'h8EA6);
    s = nlog;
    send(4'b1111, 16'h0F1E);
    hold(80, 1'b1, "R8 busy restore");
    chk(nlog - s == 2, "R1 R3 restored write count", nlog - s, 2);
    chk(log_addr[s] == 22'h000020 && log_data[s] == 8'h1E, "R1 first byte",
        log_data[s], 8'h1E);
    chk(!mem_we, "R11 strobe idle", mem_we, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule